// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block steers the front end of a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each cycle it looks at the instruction in decode and at the instruction in execute. From them it produces four control lines:

- the program-counter write enable;
- the fetch/decode latch write enable;
- a request to load a nop into the decode/execute latch;
- a flush that squashes the two younger stages when execute resolves a taken branch or jump.

The decision is combinational and takes effect in the same cycle. In the normal case the PC steps by one word. On a flush it loads the target computed in execute.

There is one stall case. It is a load in execute whose destination register is read as an execute-stage operand by the instruction directly behind it. Branches count as such readers, because their outcome comes from an ALU subtraction of two registers. A small state machine remembers whether the controller itself put a bubble into execute in the previous cycle. States are `ST_RUN` (execute holds a real instruction), `ST_AFTER_HOLD` (execute holds the nop from a stall) and `ST_AFTER_SQUASH` (execute holds the nop from a flush). The per-cycle actions are `ACT_ADVANCE`, `ACT_HOLD` and `ACT_SQUASH`. Transitions:
- `ACT_HOLD` leads to `ST_AFTER_HOLD`.
- `ACT_SQUASH` leads to `ST_AFTER_SQUASH`.
- `ACT_ADVANCE` leads to `ST_RUN`.
- In both "after" states the execute inputs are treated as a bubble, so the action there is always `ACT_ADVANCE`.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With no redirect and no load-use hazard, the outputs are pc_we=1, fd_we=1, dx_nop=0, flush=0.
- R2: A load-use hazard gives pc_we=0, fd_we=0, dx_nop=1, flush=0 in the same cycle. A load-use hazard means all of the following: execute opcode 5'b01000 (load), a nonzero execute destination, and that destination equal to a source field the decode opcode reads.
- R3: Source fields read per decode opcode:
  - both fields (a and b): 5'b00000 (register ALU), 5'b00010 and 5'b00110 (the two conditional branches);
  - field a only: 5'b00101 (immediate ALU), 5'b01000 (load), 5'b00111 (store: the store data path does not count), 5'b00100 (jump to register);
  - no field: every other code, including 5'b00001 and 5'b00011 (direct jumps).
  A match on a field that is not read never stalls.
- R4: An execute opcode other than 5'b01000 never causes a stall.
- R5: A load whose destination is register 0 never causes a stall.
- R6: ex_redirect=1 gives flush=1, dx_nop=1, pc_we=1, fd_we=1. This takes priority over a stall in the same cycle.
- R7: In the cycle after a stall, the execute inputs are ignored and the outputs are those of R1.
- R8: In the cycle after a flush, the execute inputs are ignored and the outputs are those of R1.
- R9: Reset (rst_n=0) puts the state machine in `ST_RUN`. A hazard in the first cycle after reset is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_opcode | input | OP_W | Opcode of the instruction in decode |
| dec_src_a | input | RA_W | First source register field in decode |
| dec_src_b | input | RA_W | Second source register field in decode |
| ex_opcode | input | OP_W | Opcode of the instruction in execute |
| ex_dst | input | RA_W | Destination register of the instruction in execute |
| ex_redirect | input | 1 | Execute resolved a taken branch or jump |
| pc_we | output | 1 | PC write enable |
| fd_we | output | 1 | Fetch/decode latch write enable |
| dx_nop | output | 1 | Load a nop into the decode/execute latch |
| flush | output | 1 | Squash fetch and decode; PC takes the redirect target |

## Verification
The assertions check on every cycle:
- that a stall freezes both the PC and the fetch/decode latch;
- that a flush drives all of its companion outputs;
- that a register-0 load or a non-load in execute never stalls;
- that any stall or flush is followed by a plain advance.

Only the bench's sweep can show the decode-side field-use table. That covers which opcodes read which field, and that an unread field never matches. The sweep runs over every decode opcode against loads and non-loads in execute, with small register numbers in every combination.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    // Opcode values the controller decodes (compared at OP_W bits)
    localparam int OPC_ALU  = 0;
    localparam int OPC_J    = 1;
    localparam int OPC_BNE  = 2;
    localparam int OPC_JAL  = 3;
    localparam int OPC_JR   = 4;
    localparam int OPC_ADDI = 5;
    localparam int OPC_BLT  = 6;
    localparam int OPC_SW   = 7;
    localparam int OPC_LW   = 8;

    localparam int NUM_SRC  = 2;

    typedef enum logic [1:0] {
        ST_RUN          = 2'd0,
        ST_AFTER_HOLD   = 2'd1,
        ST_AFTER_SQUASH = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_HOLD    = 2'd1,
        ACT_SQUASH  = 2'd2
    } ctl_act_e;

endpackage

// File: rtl/hzc_src_use.sv
// Decides which source register fields the decode instruction reads in execute.
module hzc_src_use
    import hzc_pkg::*;
#(
    parameter int OP_W = 5
) (
    input  logic [OP_W-1:0]    opcode,
    output logic [NUM_SRC-1:0] use_vec
);

    always_comb begin
        use_vec = '0;
        case (opcode)
            OP_W'(OPC_ALU),
            OP_W'(OPC_BNE),
            OP_W'(OPC_BLT):  use_vec = 2'b11;
            OP_W'(OPC_ADDI),
            OP_W'(OPC_LW),
            OP_W'(OPC_SW),
            OP_W'(OPC_JR):   use_vec = 2'b01;
            default:         use_vec = 2'b00;
        endcase
    end

endmodule

// File: rtl/hzc_load_use.sv
// Compares a live load destination in execute with each read source in decode.
module hzc_load_use
    import hzc_pkg::*;
#(
    parameter int OP_W = 5,
    parameter int RA_W = 5
) (
    input  logic [OP_W-1:0]              ex_opcode,
    input  logic [RA_W-1:0]              ex_dst,
    input  logic [NUM_SRC-1:0][RA_W-1:0] dec_src,
    input  logic [NUM_SRC-1:0]           use_vec,
    output logic                         hazard
);

    logic                 load_live;
    logic [NUM_SRC-1:0]   src_hit;

    assign load_live = (ex_opcode == OP_W'(OPC_LW)) && (ex_dst != '0);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign src_hit[i] = use_vec[i] && (dec_src[i] == ex_dst);
    end

    assign hazard = load_live && (|src_hit);

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hzc_pkg::*;
#(
    parameter int OP_W = 5,
    parameter int RA_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] dec_opcode,
    input  logic [RA_W-1:0] dec_src_a,
    input  logic [RA_W-1:0] dec_src_b,
    input  logic [OP_W-1:0] ex_opcode,
    input  logic [RA_W-1:0] ex_dst,
    input  logic            ex_redirect,
    output logic            pc_we,
    output logic            fd_we,
    output logic            dx_nop,
    output logic            flush
);

    ctl_state_e                  state_q;
    ctl_state_e                  state_d;
    ctl_act_e                    act;
    logic [NUM_SRC-1:0]          use_vec;
    logic [NUM_SRC-1:0][RA_W-1:0] src_pack;
    logic                        hazard;
    logic                        ex_real;

    assign src_pack = {dec_src_b, dec_src_a};

    hzc_src_use #(.OP_W(OP_W)) u_src_use (
        .opcode  (dec_opcode),
        .use_vec (use_vec)
    );

    hzc_load_use #(.OP_W(OP_W), .RA_W(RA_W)) u_load_use (
        .ex_opcode (ex_opcode),
        .ex_dst    (ex_dst),
        .dec_src   (src_pack),
        .use_vec   (use_vec),
        .hazard    (hazard)
    );

    // Execute holds a real instruction only when the previous cycle did not
    // insert a bubble there.
    assign ex_real = (state_q == ST_RUN);

    always_comb begin
        if (ex_real && ex_redirect)
            act = ACT_SQUASH;
        else if (ex_real && hazard)
            act = ACT_HOLD;
        else
            act = ACT_ADVANCE;
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:   state_d = ST_AFTER_HOLD;
            ACT_SQUASH: state_d = ST_AFTER_SQUASH;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (act)
            ACT_HOLD: begin
                pc_we  = 1'b0;
                fd_we  = 1'b0;
                dx_nop = 1'b1;
                flush  = 1'b0;
            end
            ACT_SQUASH: begin
                pc_we  = 1'b1;
                fd_we  = 1'b1;
                dx_nop = 1'b1;
                flush  = 1'b1;
            end
            default: begin
                pc_we  = 1'b1;
                fd_we  = 1'b1;
                dx_nop = 1'b0;
                flush  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
    parameter int OP_W    = 5,
    parameter int RA_W    = 5,
    parameter int LW_CODE = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] ex_opcode,
    input logic [RA_W-1:0] ex_dst,
    input logic            ex_redirect,
    input logic            pc_we,
    input logic            fd_we,
    input logic            dx_nop,
    input logic            flush
);

    logic ex_is_load;
    assign ex_is_load = (ex_opcode == OP_W'(LW_CODE));

    assert_hold_freezes_front_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dx_nop && !flush) |-> (!pc_we && !fd_we));

    assert_squash_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (pc_we && fd_we && dx_nop));

    assert_redirect_honoured_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_redirect && $past(pc_we && !dx_nop)) |-> flush);

    assert_non_load_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> pc_we);

    assert_zero_dst_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst == '0) |-> pc_we);

    assert_after_hold_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> (pc_we && !dx_nop && !flush));

    assert_after_squash_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pc_we && !dx_nop && !flush));

endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(
    .OP_W    (OP_W),
    .RA_W    (RA_W),
    .LW_CODE (hzc_pkg::OPC_LW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_opcode   (ex_opcode),
    .ex_dst      (ex_dst),
    .ex_redirect (ex_redirect),
    .pc_we       (pc_we),
    .fd_we       (fd_we),
    .dx_nop      (dx_nop),
    .flush       (flush)
);

// File: tb/pipe_hazard_ctl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_bench;

    localparam int OP_W = 5;
    localparam int RA_W = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] dec_opcode = '0;
    logic [RA_W-1:0] dec_src_a = '0;
    logic [RA_W-1:0] dec_src_b = '0;
    logic [OP_W-1:0] ex_opcode = '0;
    logic [RA_W-1:0] ex_dst = '0;
    logic            ex_redirect = 1'b0;
    logic            pc_we, fd_we, dx_nop, flush;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pipe_hazard_ctl #(.OP_W(OP_W), .RA_W(RA_W)) u_pipe_hazard_ctl (
        .clk(clk), .rst_n(rst_n),
        .dec_opcode(dec_opcode), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .ex_opcode(ex_opcode), .ex_dst(ex_dst), .ex_redirect(ex_redirect),
        .pc_we(pc_we), .fd_we(fd_we), .dx_nop(dx_nop), .flush(flush)
    );

    // Expected outputs packed as {pc_we, fd_we, dx_nop, flush}
    localparam logic [3:0] EXP_ADV   = 4'b1100;
    localparam logic [3:0] EXP_HOLD  = 4'b0010;
    localparam logic [3:0] EXP_SQUSH = 4'b1111;

    function automatic bit reads_a(input int op);
        return (op == 0 || op == 2 || op == 6 || op == 5 || op == 8 || op == 7 || op == 4);
    endfunction

    function automatic bit reads_b(input int op);
        return (op == 0 || op == 2 || op == 6);
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {pc_we, fd_we, dx_nop, flush};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: dec_op=%0d a=%0d b=%0d ex_op=%0d dst=%0d redir=%0b got=%b exp=%b",
                     tag, dec_opcode, dec_src_a, dec_src_b, ex_opcode, ex_dst,
                     ex_redirect, got, exp);
        end
    endtask

    task automatic drive(input int dop, input int a, input int b,
                         input int eop, input int d, input bit r);
        dec_opcode  = OP_W'(dop);
        dec_src_a   = RA_W'(a);
        dec_src_b   = RA_W'(b);
        ex_opcode   = OP_W'(eop);
        ex_dst      = RA_W'(d);
        ex_redirect = r;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ex_ops[3];
        ex_ops = '{8, 0, 5};
        // Reset: hazard vector driven while reset is held
        drive(0, 1, 1, 8, 1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 first cycle after reset stalls", EXP_HOLD);
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 1'b0);
        #1;
        check("R9 idle after reset", EXP_ADV);

        for (int dop = 0; dop < 32; dop++) begin
            for (int ei = 0; ei < 3; ei++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int b = 0; b < 4; b++) begin
                        for (int d = 0; d < 4; d++) begin
                            for (int r = 0; r < 2; r++) begin
                                bit hit_a, hit_b, stall_e, is_load;
                                logic [3:0] exp;
                                string tag;
                                // idle cycle returns the controller to ST_RUN
                                @(negedge clk);
                                drive(0, 0, 0, 0, 0, 1'b0);
                                @(negedge clk);
                                drive(dop, a, b, ex_ops[ei], d, r[0]);
                                is_load = (ex_ops[ei] == 8);
                                hit_a = reads_a(dop) && (a == d);
                                hit_b = reads_b(dop) && (b == d);
                                stall_e = is_load && (d != 0) && (hit_a || hit_b);
                                if (r == 1) begin
                                    exp = EXP_SQUSH; tag = "R6 redirect wins";
                                end else if (stall_e) begin
                                    exp = EXP_HOLD; tag = "R2 load-use stall";
                                end else if (is_load && d == 0) begin
                                    exp = EXP_ADV; tag = "R5 load to r0";
                                end else if (is_load && (a == d || b == d)) begin
                                    exp = EXP_ADV; tag = "R3 unread field";
                                end else if (!is_load) begin
                                    exp = EXP_ADV; tag = "R4 non-load in execute";
                                end else begin
                                    exp = EXP_ADV; tag = "R1 plain advance";
                                end
                                #1;
                                check(tag, exp);
                                if (exp != EXP_ADV) begin
                                    @(negedge clk);
                                    // worst-case execute inputs: must be ignored
                                    drive(0, 1, 1, 8, 1, 1'b1);
                                    #1;
                                    if (r == 1)
                                        check("R8 after flush", EXP_ADV);
                                    else
                                        check("R7 after stall", EXP_ADV);
                                end
                            end
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule